// File: doc/BRIEF.md
# Timer Time Base with Prescaler

This block is the counting core of a general-purpose timer. A prescaler divides the clock by a programmable factor. On each prescaled tick a counter, 16 or 32 bits wide, moves one step toward its limit. When the counter reaches its limit it wraps and raises an update event. The period limit and the prescale factor are written into preload registers. From there they are copied into working (shadow) copies, either on the next clock or only when an update event occurs.

Software writes through a narrow register port. Address 0 holds the control word, address 1 the period, address 2 the prescale value and address 3 the command strobes. An update event can also come from a one-clock software trigger or from an external slave-reset pulse. A source-select bit can restrict events to counter wraps only. A disable bit can suppress events altogether. Every event sets a sticky flag, which software clears with a strobe.

Top module: `tmr_timebase`

## Requirements
- R1: While `rst` is high and on the clock after it falls, `cnt_o`, `evt_o`, `ovf_flag_o` and `run_o` are all 0. The counter width is 16 bits after reset.
- R2: A write of 1 to control bit 0 (enable) at address 0 makes `run_o` high one clock later than the enable register. Counting only proceeds while `run_o` is high.
- R3: With shadow prescale value D, the counter takes one step every D+1 clocks while running.
- R4: When direction bit 4 is 0 and mode bits [6:5] are 00, the counter climbs from 0 to the shadow period P. On the tick after it reaches P it returns to 0, pulses `evt_o` for one clock and sets `ovf_flag_o`.
- R5: When direction bit 4 is 1, the counter steps down. On the tick after it reaches 0 it reloads P and raises the same event.
- R6: When buffer bit 3 is 0, a write to the period (address 1) or the prescale value (address 2) reaches the shadow copy on the same clock edge as the preload register.
- R7: When buffer bit 3 is 1, both shadow copies change only on an update event, when they take the preload values.
- R8: While event-disable bit 1 is 1, no event is produced and the flag is not set. The shadows are not reloaded, although the counter still wraps.
- R9: When source bit 2 is 0, a write of 1 to bit 0 at address 3 (a one-clock software trigger) or a high `slv_rst` produces an event. When source bit 2 is 1, only counter wraps produce events.
- R10: Every update event, including one from the software trigger or from `slv_rst`, restarts the prescaler count at 0.
- R11: `ovf_flag_o` stays set until a write of 1 to bit 1 at address 3. If an event and a clear happen in the same clock, the event wins.
- R12: When width bit 7 is 0, only the low 16 bits of the period and of the counter take part. When it is 1, all 32 bits do.
- R13: A shadow period of 0 holds the counter at 0 and gives an event on every prescaled tick.
- R14: When mode bits [6:5] are not 00, the counter holds its value and no wrap event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period, 2 prescale, 3 command) |
| wr_data | input | CNT_W | Write data |
| slv_rst | input | 1 | Reset pulse from a slave controller, counted as an event source |
| cnt_o | output | CNT_W | Current counter value |
| evt_o | output | 1 | One-clock update event pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| run_o | output | 1 | Internal counting enable |

## Verification
A wrong shadow value shows up on `cnt_o` at the next wrap, when the counter turns at the wrong count. A wrong prescale value shows up sooner, as a step that lands a clock early or late. A wrong event decision appears on `evt_o` one clock after its cause. It can also corrupt a buffered reload, which stays hidden until the next period. Because the bench model advances alongside the design and compares every output on every clock, each of these faults is caught on the first clock where a port differs.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word, bit 0 first: en, evt_dis, src_sel, buf_en, dir, mode[1:0], wide
  typedef struct packed {
    logic       wide;
    logic [1:0] mode;
    logic       dir;
    logic       buf_en;
    logic       src_sel;
    logic       evt_dis;
    logic       en;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam logic [1:0] MODE_EDGE = 2'b00;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             upd,
  output tmr_ctrl_t        ctrl,
  output logic [CNT_W-1:0] per_sh,
  output logic [DIV_W-1:0] div_sh,
  output logic             sw_trig,
  output logic             flag_clr
);
  logic [CNT_W-1:0] per_pre, per_nx;
  logic [DIV_W-1:0] div_pre, div_nx;
  logic             cmd_wr;

  // write decode and next preload values
  always_comb begin
    cmd_wr   = wr_en && (wr_addr == ADDR_CMD);
    flag_clr = cmd_wr && wr_data[1];
    per_nx   = (wr_en && wr_addr == ADDR_PER) ? wr_data : per_pre;
    div_nx   = (wr_en && wr_addr == ADDR_DIV) ? wr_data[DIV_W-1:0] : div_pre;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      per_pre <= '0;
      div_pre <= '0;
      per_sh  <= '0;
      div_sh  <= '0;
      sw_trig <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_CTRL)
        ctrl <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
      per_pre <= per_nx;
      div_pre <= div_nx;
      if (!ctrl.buf_en) begin
        per_sh <= per_nx;
        div_sh <= div_nx;
      end else if (upd) begin
        per_sh <= per_pre;
        div_sh <= div_pre;
      end
      sw_trig <= cmd_wr && wr_data[0];
    end
  end
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_sh,
  output logic             tick
);
  logic [DIV_W-1:0] div_cnt;

  assign tick = run && (div_cnt == div_sh);

  always_ff @(posedge clk) begin
    if (rst)            div_cnt <= '0;
    else if (clr)       div_cnt <= '0;
    else if (tick)      div_cnt <= '0;
    else if (run)       div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dir,
  input  logic [1:0]       mode,
  input  logic             wide,
  input  logic [CNT_W-1:0] per_sh,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] NARROW_MASK =
    {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0] mask, lim, cnt_nx;
  logic             step, at_lim;

  always_comb begin
    mask   = wide ? '1 : NARROW_MASK;
    lim    = per_sh & mask;
    step   = tick && (mode == MODE_EDGE);
    at_lim = dir ? (cnt == '0) : (cnt >= lim);
    wrap   = step && at_lim;
    cnt_nx = cnt;
    if (step) begin
      if (dir) cnt_nx = at_lim ? lim : ((cnt - 1'b1) & mask);
      else     cnt_nx = at_lim ? '0  : ((cnt + 1'b1) & mask);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16,
  parameter int DIV_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             slv_rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             evt_o,
  output logic             ovf_flag_o,
  output logic             run_o
);
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] per_sh;
  logic [DIV_W-1:0] div_sh;
  logic             sw_trig, flag_clr, pre_tick, wrap, evt_raw;

  tmr_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd(evt_raw), .ctrl(ctrl), .per_sh(per_sh), .div_sh(div_sh),
    .sw_trig(sw_trig), .flag_clr(flag_clr)
  );

  tmr_presc #(.DIV_W(DIV_W)) presc_i (
    .clk(clk), .rst(rst), .run(run_o), .clr(evt_raw), .div_sh(div_sh),
    .tick(pre_tick)
  );

  tmr_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) count_i (
    .clk(clk), .rst(rst), .tick(pre_tick), .dir(ctrl.dir), .mode(ctrl.mode),
    .wide(ctrl.wide), .per_sh(per_sh), .cnt(cnt_o), .wrap(wrap)
  );

  // event source selection and suppression
  assign evt_raw = !ctrl.evt_dis &&
                   (wrap || (!ctrl.src_sel && (sw_trig || slv_rst)));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o      <= 1'b0;
      evt_o      <= 1'b0;
      ovf_flag_o <= 1'b0;
    end else begin
      run_o <= ctrl.en;
      evt_o <= evt_raw;
      if (evt_raw)       ovf_flag_o <= 1'b1;
      else if (flag_clr) ovf_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             pre_tick,
  input logic             evt_raw,
  input logic             evt_dis,
  input logic             buf_en,
  input logic [CNT_W-1:0] per_sh,
  input logic [CNT_W-1:0] cnt_o,
  input logic             evt_o,
  input logic             ovf_flag_o
);
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pre_tick) |-> (cnt_o == $past(cnt_o)));

  // R8
  evt_block_chk: assert property (@(posedge clk) disable iff (rst)
    $past(evt_dis) |-> !evt_o);

  // R11
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    evt_o |-> ovf_flag_o);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(buf_en) && !$past(evt_raw)) |-> (per_sh == $past(per_sh)));
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .pre_tick(pre_tick), .evt_raw(evt_raw),
  .evt_dis(ctrl.evt_dis), .buf_en(ctrl.buf_en), .per_sh(per_sh),
  .cnt_o(cnt_o), .evt_o(evt_o), .ovf_flag_o(ovf_flag_o)
);

// File: tb/tmr_timebase_tb_top.sv
module tmr_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        slv_rst = 1'b0;
  logic [31:0] cnt_o;
  logic        evt_o, ovf_flag_o, run_o;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    cmp_on = 1'b0, done = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  tmr_timebase dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slv_rst(slv_rst), .cnt_o(cnt_o), .evt_o(evt_o), .ovf_flag_o(ovf_flag_o),
    .run_o(run_o)
  );

  // behavioural reference state
  logic        m_en, m_dis, m_src, m_buf, m_dir, m_wide, m_run, m_sw, m_evt, m_flag;
  logic [1:0]  m_mode;
  logic [31:0] m_pper, m_sper, m_cnt;
  logic [15:0] m_pdiv, m_sdiv, m_dcnt;

  always @(posedge clk) begin
    logic [31:0] msk, lim, ncnt, nsper, npper;
    logic [15:0] nsdiv, npdiv, ndcnt;
    logic        tick, wrap, ev, clr;
    if (rst) begin
      {m_en, m_dis, m_src, m_buf, m_dir, m_wide, m_run, m_sw, m_evt, m_flag} = '0;
      m_mode = 0; m_pper = 0; m_sper = 0; m_cnt = 0;
      m_pdiv = 0; m_sdiv = 0; m_dcnt = 0;
    end else begin
      msk  = m_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      lim  = m_sper & msk;
      tick = m_run && (m_dcnt == m_sdiv);
      ncnt = m_cnt;
      wrap = 1'b0;
      if (tick && m_mode == 2'b00) begin
        if (m_dir) begin
          if (m_cnt == 0) begin ncnt = lim; wrap = 1'b1; end
          else ncnt = (m_cnt - 1) & msk;
        end else begin
          if (m_cnt >= lim) begin ncnt = 0; wrap = 1'b1; end
          else ncnt = (m_cnt + 1) & msk;
        end
      end
      ev  = !m_dis && (wrap || (!m_src && (m_sw || slv_rst)));
      clr = wr_en && wr_addr == 2'd3 && wr_data[1];
      ndcnt = (ev || tick) ? 16'd0 : (m_run ? m_dcnt + 16'd1 : m_dcnt);
      npper = (wr_en && wr_addr == 2'd1) ? wr_data : m_pper;
      npdiv = (wr_en && wr_addr == 2'd2) ? wr_data[15:0] : m_pdiv;
      nsper = m_sper; nsdiv = m_sdiv;
      if (!m_buf) begin nsper = npper; nsdiv = npdiv; end
      else if (ev) begin nsper = m_pper; nsdiv = m_pdiv; end
      m_run  = m_en;
      m_evt  = ev;
      m_flag = ev ? 1'b1 : (clr ? 1'b0 : m_flag);
      m_sw   = wr_en && wr_addr == 2'd3 && wr_data[0];
      m_cnt  = ncnt; m_dcnt = ndcnt;
      m_pper = npper; m_pdiv = npdiv; m_sper = nsper; m_sdiv = nsdiv;
      if (wr_en && wr_addr == 2'd0) begin
        m_en = wr_data[0]; m_dis = wr_data[1]; m_src = wr_data[2]; m_buf = wr_data[3];
        m_dir = wr_data[4]; m_mode = wr_data[6:5]; m_wide = wr_data[7];
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", phase, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("cnt_o", cnt_o, m_cnt);
      chk("evt_o", {31'd0, evt_o}, {31'd0, m_evt});
      chk("ovf_flag_o", {31'd0, ovf_flag_o}, {31'd0, m_flag});
      chk("run_o", {31'd0, run_o}, {31'd0, m_run});
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      summary();
    end
  end

  function automatic logic [31:0] ctl(bit en, bit dis, bit src, bit bf, bit dir,
                                      bit [1:0] mode, bit wide);
    return {24'd0, wide, mode, dir, bf, src, dis, en};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #5;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #5;
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic pulse_slv();
    @(posedge clk); #5; slv_rst = 1'b1;
    @(posedge clk); #5; slv_rst = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    phase = "R1";
    @(posedge clk); cmp_on = 1'b1;
    idle(2); #5; rst = 1'b0;
    idle(3);
    phase = "R6";                       // unbuffered: immediate shadow
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd1);
    phase = "R2";
    wr(2'd0, ctl(1,0,0,0,0,2'b00,0));
    idle(3);
    phase = "R4";                       // upcount with prescaler R3
    idle(30);
    phase = "R11";
    wr(2'd3, 32'd2);
    idle(14);
    wr(2'd3, 32'd2);
    idle(4);
    phase = "R7";
    wr(2'd0, ctl(1,0,0,1,0,2'b00,0));
    wr(2'd1, 32'd9);
    wr(2'd2, 32'd0);
    idle(40);
    phase = "R9";
    wr(2'd0, ctl(1,0,0,0,0,2'b00,0));
    wr(2'd1, 32'd20);
    wr(2'd2, 32'd2);
    idle(6);
    wr(2'd3, 32'd1);
    idle(3);
    pulse_slv();
    idle(3);
    wr(2'd0, ctl(1,0,1,0,0,2'b00,0));
    wr(2'd3, 32'd1);
    pulse_slv();
    idle(5);
    phase = "R10";
    wr(2'd0, ctl(1,0,0,0,0,2'b00,0));
    wr(2'd2, 32'd3);
    wr(2'd3, 32'd1);
    idle(6);
    wr(2'd3, 32'd1);
    idle(10);
    phase = "R8";
    wr(2'd1, 32'd4);
    wr(2'd2, 32'd0);
    wr(2'd0, ctl(1,1,0,1,0,2'b00,0));
    wr(2'd1, 32'd2);
    wr(2'd3, 32'd3);
    pulse_slv();
    idle(20);
    wr(2'd0, ctl(1,0,0,1,0,2'b00,0));
    idle(15);
    phase = "R5";
    wr(2'd0, ctl(1,0,0,0,1,2'b00,0));
    wr(2'd1, 32'd4);
    idle(20);
    phase = "R12";
    wr(2'd0, ctl(1,0,0,0,0,2'b00,0));
    wr(2'd1, 32'h0001_0003);
    idle(15);
    wr(2'd0, ctl(1,0,0,0,0,2'b00,1));
    idle(20);
    phase = "R13";
    wr(2'd0, ctl(1,0,0,0,0,2'b00,0));
    wr(2'd1, 32'd0);
    idle(10);
    phase = "R14";
    wr(2'd1, 32'd6);
    idle(4);
    wr(2'd0, ctl(1,0,0,0,0,2'b01,0));
    idle(12);
    phase = "R2";
    wr(2'd0, ctl(0,0,0,0,0,2'b00,0));
    idle(5);
    @(negedge clk); #1;
    done = 1'b1;
    summary();
  end
endmodule